// File: doc/BRIEF.md
# Masked Configuration Register File

This block holds the configuration dwords of a bridge-style header, plus one capability dword for device control and status. Every bit of every dword follows one of four policies. A read-only bit keeps its reset value. A read-write bit takes whatever software writes. A write-one-to-clear bit is cleared when software writes a one to it. A reserved bit always reads as zero. The policy of each dword is a constant worked out from its index and from two support parameters.

Software issues a request with a byte offset, a size of 1, 2 or 4 bytes and, for a write, the data. A write merges into the stored dword through a byte-lane mask. Only the read-write and write-one-to-clear bits under that mask can change. A read returns the addressed bytes shifted down to bit 0, and reserved bits come back as zero. Hardware pulses `statusSet` to raise status flags. When the I/O window or the prefetchable window is not supported, the parameters turn its registers read-only. The response comes one cycle after the request.

Top module: `cfg_regfile`

## Requirements
- R1: Bits outside all three policy masks read as 0 whatever is written. This includes every bit of dwords 9 and up, and bits [31:16] of the I/O window dword at byte offset 0x10.
- R2: A write of size 1, 2 or 4 only affects bits under the lane mask. That mask is 0xFF, 0xFFFF or all ones, shifted left by 8 times offset[1:0].
- R3: Read-only bits never change. In the I/O window dword (offset 0x10), bits [15:12] and [7:4] are read-write and bits [11:8] and [3:0] are read-only. Command bits [2:0] at offset 0x04 are read-write.
- R4: Writing 1 to a write-one-to-clear bit under the lane mask clears it. Writing 0 leaves it unchanged.
- R5: A read of size 1 or 2 returns the dword shifted right by 8 times offset[1:0], masked to 8 or 16 bits.
- R6: Reset values: dword 0 is ID_WORD, cache line size byte (offset 0x0C) is 0x10, header type byte (offset 0x0E) is 0x01, status bit 20 of offset 0x04 (capability list present) is 1.
- R7: In the memory window dwords (offsets 0x14 and 0x18), bits [31:20] and [15:4] are read-write and bits [19:16] and [3:0] are read-only zero.
- R8: In the device status half of offset 0x20, bits 22 and [19:16] are write-one-to-clear, bits [21:20] are read-only (reset 2'b01) and the rest is reserved. Bits [14:0] of device control are read-write.
- R9: With PREF_ON=0 the whole dword at offset 0x18 is read-only, so writes leave it unchanged.
- R10: With IO_ON=0 the following are read-only: command bit 0, bits [15:0] of offset 0x10 and all of offset 0x1C.
- R11: A size other than 1, 2 or 4 gives rspErr=1 with rspRdata=0 and leaves all stored bits unchanged.
- R12: statusSet bit 4 sets status bit 22 and bits [3:0] set bits [19:16]. If a software clear hits the same bit in the same cycle, the set wins.
- R13: rspValid is high exactly one cycle after each request. rspRdata is 0 for any response other than a good read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | OFS_W | Byte offset |
| reqSize | input | 3 | Access size in bytes |
| reqWdata | input | 32 | Write data, right-aligned |
| statusSet | input | 5 | Hardware status-set pulses |
| rspValid | output | 1 | Response strobe |
| rspErr | output | 1 | Illegal size flag |
| rspRdata | output | 32 | Aligned read data |

## Verification
Reads of all three sizes at several lane offsets test the alignment. They tell a correct shift from a byte-swap or a truncation. All-ones writes to dwords with mixed policies separate the read-write, read-only and reserved bits. Narrow writes into a dword that was filled earlier show whether neighbouring lanes survive. Status bits are set by hardware and then written with zeros, with a single one, and with a clear that arrives together with a set. These cases tell clearing from ignoring and show which side wins. A second instance with both windows unsupported receives the same writes, so the policy variants are compared side by side.

// File: rtl/cfg_regfile_pkg.sv
package cfg_regfile_pkg;

  localparam int unsigned WORD_BITS = 32;
  localparam int unsigned IDX_BITS  = 8;
  localparam int unsigned STAT_IDX  = 8;

  typedef struct packed {
    logic [WORD_BITS-1:0] ro;
    logic [WORD_BITS-1:0] rw;
    logic [WORD_BITS-1:0] w1c;
  } bitPolicy_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    logic                 badReq;
    logic [IDX_BITS-1:0]  idx;
    logic [WORD_BITS-1:0] laneMask;
    logic [4:0]           shift;
    logic [1:0]           sizeSel;   // 0: byte, 1: half, 2: word
  } ctrlStrb_t;

  function automatic bitPolicy_t policyOf(int unsigned idx, bit ioOn, bit prefOn);
    bitPolicy_t p;
    p = '{ro: '0, rw: '0, w1c: '0};
    case (idx)
      0, 2, 3: p.ro = '1;
      1: begin
        p.rw  = ioOn ? 32'h0000_0007 : 32'h0000_0006;
        p.ro  = ioOn ? 32'h0010_0000 : 32'h0010_0001;
        p.w1c = 32'hF800_0000;
      end
      4: begin
        p.rw = ioOn ? 32'h0000_F0F0 : 32'h0000_0000;
        p.ro = ioOn ? 32'h0000_0F0F : 32'h0000_FFFF;
      end
      5: begin
        p.rw = 32'hFFF0_FFF0;
        p.ro = 32'h000F_000F;
      end
      6: begin
        p.rw = prefOn ? 32'hFFF0_FFF0 : 32'h0000_0000;
        p.ro = prefOn ? 32'h000F_000F : 32'hFFFF_FFFF;
      end
      7: begin
        p.rw = ioOn ? 32'hFFFF_FFFF : 32'h0000_0000;
        p.ro = ioOn ? 32'h0000_0000 : 32'hFFFF_FFFF;
      end
      STAT_IDX: begin
        p.rw  = 32'h0000_7FFF;
        p.ro  = 32'h0030_0000;
        p.w1c = 32'h004F_0000;
      end
      default: ;
    endcase
    return p;
  endfunction

  function automatic logic [WORD_BITS-1:0] resetOf(int unsigned idx,
      logic [WORD_BITS-1:0] idWord, logic [WORD_BITS-1:0] classWord);
    case (idx)
      0:        return idWord;
      1:        return 32'h0010_0000;
      2:        return classWord;
      3:        return 32'h0001_0010;
      STAT_IDX: return 32'h0010_0000;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [WORD_BITS-1:0] setMap(logic [4:0] s);
    return {9'b0, s[4], 2'b0, s[3:0], 16'b0};
  endfunction

endpackage

// File: rtl/cfg_regfile_ctrl.sv
module cfg_regfile_ctrl
  import cfg_regfile_pkg::*;
#(
  parameter int unsigned OFS_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic [2:0]       reqSize,
  output ctrlStrb_t        strb,
  output logic             rspValid,
  output logic             rspErr
);

  logic sizeOk;
  logic [WORD_BITS-1:0] baseMask;

  always_comb begin
    sizeOk = (reqSize == 3'd1) || (reqSize == 3'd2) || (reqSize == 3'd4);
    case (reqSize)
      3'd1:    baseMask = 32'h0000_00FF;
      3'd2:    baseMask = 32'h0000_FFFF;
      3'd4:    baseMask = 32'hFFFF_FFFF;
      default: baseMask = '0;
    endcase
    strb.shift    = {reqOffset[1:0], 3'b000};
    strb.laneMask = baseMask << strb.shift;
    strb.wrEn     = reqValid && reqWrite && sizeOk;
    strb.rdEn     = reqValid && !reqWrite && sizeOk;
    strb.badReq   = reqValid && !sizeOk;
    strb.idx      = IDX_BITS'(reqOffset[OFS_W-1:2]);
    strb.sizeSel  = (reqSize == 3'd1) ? 2'd0 : (reqSize == 3'd2) ? 2'd1 : 2'd2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= reqValid && !sizeOk;
    end
  end

  // R13: one response per request, one cycle later
  assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_rsp_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

endmodule

// File: rtl/cfg_regfile_datapath.sv
module cfg_regfile_datapath
  import cfg_regfile_pkg::*;
#(
  parameter int unsigned          NUM_DW     = 16,
  parameter bit                   IO_ON      = 1'b1,
  parameter bit                   PREF_ON    = 1'b1,
  parameter logic [WORD_BITS-1:0] ID_WORD    = 32'hC0DE_0001,
  parameter logic [WORD_BITS-1:0] CLASS_WORD = 32'h0604_0001
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic [WORD_BITS-1:0] wrData,
  input  logic [4:0]           statusSet,
  output logic [WORD_BITS-1:0] rdData
);

  localparam int unsigned IDXW = $clog2(NUM_DW);

  logic [NUM_DW-1:0][WORD_BITS-1:0] regs;
  logic [NUM_DW-1:0][WORD_BITS-1:0] liveMask;
  logic [WORD_BITS-1:0] wv;
  logic [WORD_BITS-1:0] setVec;
  logic                 inRange;

  assign wv      = wrData << strb.shift;
  assign setVec  = setMap(statusSet);
  assign inRange = (strb.idx < IDX_BITS'(NUM_DW));

  for (genvar i = 0; i < NUM_DW; i++) begin : g_dw
    localparam bitPolicy_t POL = policyOf(i, IO_ON, PREF_ON);
    localparam logic [WORD_BITS-1:0] RST = resetOf(i, ID_WORD, CLASS_WORD)
                                          & (POL.ro | POL.rw | POL.w1c);
    logic [WORD_BITS-1:0] nxt;
    logic                 hit;

    assign liveMask[i] = POL.ro | POL.rw | POL.w1c;
    assign hit = strb.wrEn && (strb.idx == IDX_BITS'(i));

    always_comb begin
      nxt = regs[i];
      if (hit) begin
        nxt = (nxt & ~(POL.rw & strb.laneMask)) | (wv & POL.rw & strb.laneMask);
        nxt = nxt & ~(wv & POL.w1c & strb.laneMask);
      end
      if (i == STAT_IDX) nxt = nxt | (setVec & POL.w1c);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regs[i] <= RST;
      else       regs[i] <= nxt;
    end

    // R3: read-only bits hold their value
    assert_ro_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
      $stable(regs[i] & POL.ro));
    // R1: reserved storage stays clear
    assert_rsvd_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
      (regs[i] & ~liveMask[i]) == '0);
  end

  logic [WORD_BITS-1:0] rawWord;
  logic [WORD_BITS-1:0] shifted;

  always_comb begin
    rawWord = inRange ? (regs[strb.idx[IDXW-1:0]] & liveMask[strb.idx[IDXW-1:0]]) : '0;
    shifted = rawWord >> strb.shift;
    case (strb.sizeSel)
      2'd0:    shifted = shifted & 32'h0000_00FF;
      2'd1:    shifted = shifted & 32'h0000_FFFF;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= shifted;
    else                rdData <= '0;
  end

  // R11: a rejected request leaves storage untouched
  assert_err_keeps_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.badReq && statusSet == '0) |=> $stable(regs));
  // R12: hardware set always lands
  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rstN)
    (statusSet != '0) |=> ((regs[STAT_IDX] & $past(setVec)) == $past(setVec)));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_regfile_pkg::*;
#(
  parameter int unsigned OFS_W      = 6,
  parameter bit          IO_ON      = 1'b1,
  parameter bit          PREF_ON    = 1'b1,
  parameter logic [31:0] ID_WORD    = 32'hC0DE_0001,
  parameter logic [31:0] CLASS_WORD = 32'h0604_0001
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic [2:0]       reqSize,
  input  logic [31:0]      reqWdata,
  input  logic [4:0]       statusSet,
  output logic             rspValid,
  output logic             rspErr,
  output logic [31:0]      rspRdata
);

  localparam int unsigned NUM_DW = 2 ** (OFS_W - 2);

  ctrlStrb_t strb;

  cfg_regfile_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqSize(reqSize), .strb(strb),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  cfg_regfile_datapath #(
    .NUM_DW(NUM_DW), .IO_ON(IO_ON), .PREF_ON(PREF_ON),
    .ID_WORD(ID_WORD), .CLASS_WORD(CLASS_WORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(reqWdata),
    .statusSet(statusSet), .rdData(rspRdata)
  );

  // R11: rejected requests return no data
  assert_err_nodata_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspRdata == '0));

endmodule

// File: tb/cfg_regfile_bench.sv
module cfg_regfile_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [5:0]  reqOffset = '0;
  logic [2:0]  reqSize = 3'd4;
  logic [31:0] reqWdata = '0;
  logic [4:0]  statusSet = '0;
  logic        vA, eA, vB, eB;
  logic [31:0] dA, dB;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  cfg_regfile u_cfg_regfile (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqWdata(reqWdata),
    .statusSet(statusSet), .rspValid(vA), .rspErr(eA), .rspRdata(dA)
  );

  cfg_regfile #(.IO_ON(1'b0), .PREF_ON(1'b0)) u_cfg_regfile_nowin (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqWdata(reqWdata),
    .statusSet(statusSet), .rspValid(vB), .rspErr(eB), .rspRdata(dB)
  );

  typedef struct packed {
    bit        wr;
    bit [5:0]  ofs;
    bit [2:0]  sz;
    bit [31:0] wd;
    bit [31:0] exp;
    bit        err;
    bit [7:0]  req;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 6'h00, 3'd4, 32'h0, 32'hC0DE_0001, 1'b0, 8'd6},  // R6
    '{1'b0, 6'h0C, 3'd1, 32'h0, 32'h0000_0010, 1'b0, 8'd6},  // R6
    '{1'b0, 6'h0E, 3'd1, 32'h0, 32'h0000_0001, 1'b0, 8'd6},  // R6
    '{1'b0, 6'h06, 3'd2, 32'h0, 32'h0000_0010, 1'b0, 8'd6},  // R6
    '{1'b1, 6'h10, 3'd4, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd3},  // R3
    '{1'b0, 6'h10, 3'd4, 32'h0, 32'h0000_F0F0, 1'b0, 8'd3},  // R3 R1
    '{1'b1, 6'h11, 3'd1, 32'h0, 32'h0, 1'b0, 8'd2},          // R2
    '{1'b0, 6'h10, 3'd4, 32'h0, 32'h0000_00F0, 1'b0, 8'd2},  // R2
    '{1'b1, 6'h14, 3'd4, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd7},  // R7
    '{1'b0, 6'h14, 3'd4, 32'h0, 32'hFFF0_FFF0, 1'b0, 8'd7},  // R7
    '{1'b1, 6'h16, 3'd2, 32'h1234, 32'h0, 1'b0, 8'd2},       // R2
    '{1'b0, 6'h14, 3'd4, 32'h0, 32'h1230_FFF0, 1'b0, 8'd2},  // R2
    '{1'b0, 6'h17, 3'd1, 32'h0, 32'h0000_0012, 1'b0, 8'd5},  // R5
    '{1'b0, 6'h14, 3'd2, 32'h0, 32'h0000_FFF0, 1'b0, 8'd5},  // R5
    '{1'b0, 6'h15, 3'd1, 32'h0, 32'h0000_00FF, 1'b0, 8'd5},  // R5
    '{1'b1, 6'h24, 3'd4, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd1},  // R1
    '{1'b0, 6'h24, 3'd4, 32'h0, 32'h0, 1'b0, 8'd1},          // R1
    '{1'b1, 6'h00, 3'd4, 32'h0, 32'h0, 1'b0, 8'd3},          // R3
    '{1'b0, 6'h00, 3'd4, 32'h0, 32'hC0DE_0001, 1'b0, 8'd3},  // R3
    '{1'b1, 6'h14, 3'd3, 32'h0, 32'h0, 1'b1, 8'd11},         // R11
    '{1'b0, 6'h14, 3'd4, 32'h0, 32'h1230_FFF0, 1'b0, 8'd11}, // R11
    '{1'b0, 6'h14, 3'd0, 32'h0, 32'h0, 1'b1, 8'd11},         // R11
    '{1'b1, 6'h04, 3'd4, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd3},  // R3
    '{1'b0, 6'h04, 3'd4, 32'h0, 32'h0010_0007, 1'b0, 8'd3},  // R3
    '{1'b1, 6'h18, 3'd4, 32'hABCD_1234, 32'h0, 1'b0, 8'd7}   // R7
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Request in one cycle, response sampled at the following negedge
  task automatic doReq(input bit wr, input logic [5:0] ofs, input logic [2:0] sz,
                       input logic [31:0] wd, input logic [4:0] setv);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqOffset = ofs; reqSize = sz;
    reqWdata = wd; statusSet = setv;
    @(negedge clk);
    reqValid = 1'b0; statusSet = '0;
    chk(13, {31'b0, vA}, 32'd1);  // R13
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(13, {31'b0, vA}, 32'd0);  // R13 during reset
    chk(13, dA, 32'd0);           // R13 during reset
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      doReq(TBL[i].wr, TBL[i].ofs, TBL[i].sz, TBL[i].wd, 5'd0);
      chk(TBL[i].req, dA, TBL[i].exp);
      chk(TBL[i].req, {31'b0, eA}, {31'b0, TBL[i].err});
    end

    doReq(1'b0, 6'h18, 3'd4, 0, 0); chk(7, dA, 32'hABC0_1230);  // R7
    chk(9, dB, 32'h0);                                           // R9
    doReq(1'b0, 6'h10, 3'd4, 0, 0); chk(10, dB, 32'h0);          // R10
    doReq(1'b0, 6'h04, 3'd4, 0, 0); chk(10, dB, 32'h0010_0006);  // R10
    doReq(1'b1, 6'h1C, 3'd4, 32'hFFFF_FFFF, 0);
    doReq(1'b0, 6'h1C, 3'd4, 0, 0);
    chk(10, dB, 32'h0);            // R10
    chk(3, dA, 32'hFFFF_FFFF);     // R3 supported variant is writable

    @(negedge clk);
    chk(13, {31'b0, vA}, 32'd0);   // R13 idle

    // Status set, clear and race
    @(negedge clk); statusSet = 5'h1F; @(negedge clk); statusSet = '0;
    doReq(1'b0, 6'h20, 3'd4, 0, 0); chk(12, dA, 32'h005F_0000);  // R12
    doReq(1'b1, 6'h22, 3'd2, 32'h0, 0);
    doReq(1'b0, 6'h22, 3'd2, 0, 0); chk(4, dA, 32'h0000_005F);   // R4
    doReq(1'b1, 6'h22, 3'd1, 32'h01, 0);
    doReq(1'b0, 6'h22, 3'd2, 0, 0); chk(4, dA, 32'h0000_005E);   // R4
    doReq(1'b1, 6'h22, 3'd1, 32'h01, 5'h01);
    doReq(1'b0, 6'h22, 3'd2, 0, 0); chk(12, dA, 32'h0000_005F);  // R12
    doReq(1'b1, 6'h20, 3'd4, 32'hFFFF_FFFF, 0);
    doReq(1'b0, 6'h20, 3'd4, 0, 0); chk(8, dA, 32'h0010_7FFF);   // R8

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule